// File: doc/BRIEF.md
# Sliding-Window Approximate Average Unit

This unit accepts one unsigned 8-bit sample on every clock edge and keeps the nine most recent samples in a sliding window. For the current window it takes the integer part of the arithmetic mean. It then snaps that value to a sample that is actually stored: the mean itself when some stored sample equals it, otherwise the largest stored sample that lies strictly below it.

The 10-bit result adds the approximate average to each of the nine stored samples, sums those nine terms, divides the total by eight and drops the remainder. A valid flag tells downstream logic when the window has been filled since reset. After that point, every new input sample produces one new result.

The window state is registered. The result is produced by combinational logic from that state, so it reflects the window that includes the sample captured at the most recent clock edge.

Top module: `approx_avg_unit`

## Requirements
- R1: Each rising clock edge with reset low shifts `x_in` into the window and drops the oldest sample, so the window always holds the last nine samples captured.
- R2: The mean is the sum of the nine stored samples divided by nine, with the fraction discarded.
- R3: When at least one stored sample equals the truncated mean, the approximate average equals the truncated mean.
- R4: When no stored sample equals the truncated mean, the approximate average is the largest stored sample strictly below the truncated mean.
- R5: `y_out` equals (window sum + 9 × approximate average) / 8, with the remainder discarded. With nine stored samples all equal to 255, `y_out` is 573.
- R6: While `rst` is high at a rising edge, the window is cleared to zero and the fill count is cleared. In the cycle after that edge, `y_valid` is 0 and `y_out` is 0.
- R7: `y_valid` is 0 after the first eight samples since reset and rises with the ninth. It then stays high until the next reset.
- R8: With the window 143, 11, 93, 32, 243, 62, 229, 3, 12 (oldest first), `y_out` is 173. After 116 is shifted in next, `y_out` is 169.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 8 | Unsigned sample captured every cycle |
| y_out | output | 10 | Unsigned result for the current window |
| y_valid | output | 1 | High once nine samples have entered the window since reset |

## Verification
The assertions assume two things about the inputs. First, reset is applied before the first result is used. Second, `x_in` carries a defined value at every rising edge, because every edge captures a sample and there is no input qualifier. The stimulus meets both conditions. It holds reset for the first cycles and changes `x_in` only at falling edges, always to a defined value. The values come from a fixed-seed generator mixed with directed windows: the reference pair, uniform windows where the mean is present, all-maximum samples, and a reset in the middle of a run.

// File: rtl/aa_pkg.sv
package aa_pkg;

    localparam int unsigned AA_WIN_DEF      = 9;
    localparam int unsigned AA_SAMPLE_W_DEF = 8;

    // Width that holds the sum of win samples of sw bits each
    function automatic int unsigned aa_sum_w(int unsigned win, int unsigned sw);
        return sw + $clog2(win);
    endfunction

    typedef enum logic [0:0] {
        FILLING   = 1'b0,
        STREAMING = 1'b1
    } fill_e;

endpackage

// File: rtl/aa_window.sv
module aa_window
    import aa_pkg::*;
#(
    parameter int unsigned WIN      = AA_WIN_DEF,
    parameter int unsigned SAMPLE_W = AA_SAMPLE_W_DEF,
    localparam int unsigned SUM_W   = aa_sum_w(WIN, SAMPLE_W),
    localparam int unsigned CNT_W   = $clog2(WIN)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SAMPLE_W-1:0]           x_in,
    output logic [WIN-1:0][SAMPLE_W-1:0]  taps,
    output logic [SUM_W-1:0]              sum,
    output logic                          full
);

    logic [WIN-1:0][SAMPLE_W-1:0] taps_q;
    logic [SUM_W-1:0]             sum_q;
    logic [CNT_W-1:0]             cnt_q;
    fill_e                        state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            taps_q  <= '0;
            sum_q   <= '0;
            cnt_q   <= '0;
            state_q <= FILLING;
        end else begin
            taps_q[0] <= x_in;
            for (int i = 1; i < WIN; i++) begin
                taps_q[i] <= taps_q[i-1];
            end
            sum_q <= sum_q + SUM_W'(x_in) - SUM_W'(taps_q[WIN-1]);
            if (state_q == FILLING) begin
                if (cnt_q == CNT_W'(WIN-1)) begin
                    state_q <= STREAMING;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign taps = taps_q;
    assign sum  = sum_q;
    assign full = (state_q == STREAMING);

    // Independent adder tree for checking the running total
    logic [SUM_W-1:0] tap_total;
    always_comb begin
        tap_total = '0;
        for (int i = 0; i < WIN; i++) begin
            tap_total = tap_total + SUM_W'(taps_q[i]);
        end
    end

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
        sum_q == tap_total); // R1

    AST_NEWEST_TAP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> taps_q[0] == $past(x_in)); // R1

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
        full |=> full); // R7

endmodule

// File: rtl/aa_select.sv
module aa_select
    import aa_pkg::*;
#(
    parameter int unsigned WIN      = AA_WIN_DEF,
    parameter int unsigned SAMPLE_W = AA_SAMPLE_W_DEF,
    localparam int unsigned SUM_W   = aa_sum_w(WIN, SAMPLE_W)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [WIN-1:0][SAMPLE_W-1:0]  taps,
    input  logic [SUM_W-1:0]              sum,
    output logic [SAMPLE_W-1:0]           approx
);

    logic [SAMPLE_W-1:0] mean;
    logic [WIN-1:0]      le_mean;
    logic [WIN-1:0]      eq_mean;
    logic                hit;

    // Truncated mean; a mean of samples never exceeds the sample range
    assign mean = SAMPLE_W'(sum / SUM_W'(WIN));

    for (genvar g = 0; g < WIN; g++) begin : g_cmp
        assign le_mean[g] = (taps[g] <= mean);
        assign eq_mean[g] = (taps[g] == mean);
    end

    assign hit = |eq_mean;

    // Largest tap not above the mean; the minimum tap always qualifies
    always_comb begin
        approx = '0;
        for (int i = 0; i < WIN; i++) begin
            if (le_mean[i] && taps[i] > approx) begin
                approx = taps[i];
            end
        end
    end

    AST_APPROX_NOT_ABOVE: assert property (@(posedge clk) disable iff (rst)
        approx <= mean); // R4

    AST_HIT_EXACT: assert property (@(posedge clk) disable iff (rst)
        hit |-> approx == mean); // R3

    AST_MISS_BELOW: assert property (@(posedge clk) disable iff (rst)
        !hit |-> approx < mean); // R4

endmodule

// File: rtl/aa_result.sv
module aa_result
    import aa_pkg::*;
#(
    parameter int unsigned WIN      = AA_WIN_DEF,
    parameter int unsigned SAMPLE_W = AA_SAMPLE_W_DEF,
    localparam int unsigned SUM_W   = aa_sum_w(WIN, SAMPLE_W),
    localparam int unsigned NUM_W   = SUM_W + 1,
    localparam int unsigned Y_W     = NUM_W - $clog2(WIN-1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SUM_W-1:0]     sum,
    input  logic [SAMPLE_W-1:0]  approx,
    output logic [Y_W-1:0]       y
);

    logic [NUM_W-1:0] num;

    assign num = NUM_W'(sum) + NUM_W'(approx) * NUM_W'(WIN);
    assign y   = Y_W'(num / NUM_W'(WIN-1));

    AST_Y_FLOOR: assert property (@(posedge clk) disable iff (rst)
        NUM_W'(y) >= NUM_W'(approx) * NUM_W'(2)); // R5

endmodule

// File: rtl/approx_avg_unit.sv
module approx_avg_unit
    import aa_pkg::*;
#(
    parameter int unsigned WIN      = AA_WIN_DEF,
    parameter int unsigned SAMPLE_W = AA_SAMPLE_W_DEF,
    localparam int unsigned SUM_W   = aa_sum_w(WIN, SAMPLE_W),
    localparam int unsigned Y_W     = SUM_W + 1 - $clog2(WIN-1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SAMPLE_W-1:0]  x_in,
    output logic [Y_W-1:0]       y_out,
    output logic                 y_valid
);

    logic [WIN-1:0][SAMPLE_W-1:0] taps;
    logic [SUM_W-1:0]             sum;
    logic [SAMPLE_W-1:0]          approx;

    aa_window #(.WIN(WIN), .SAMPLE_W(SAMPLE_W)) u_window (
        .clk  (clk),
        .rst  (rst),
        .x_in (x_in),
        .taps (taps),
        .sum  (sum),
        .full (y_valid)
    );

    aa_select #(.WIN(WIN), .SAMPLE_W(SAMPLE_W)) u_select (
        .clk    (clk),
        .rst    (rst),
        .taps   (taps),
        .sum    (sum),
        .approx (approx)
    );

    aa_result #(.WIN(WIN), .SAMPLE_W(SAMPLE_W)) u_result (
        .clk    (clk),
        .rst    (rst),
        .sum    (sum),
        .approx (approx),
        .y      (y_out)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!y_valid && y_out == '0)); // R6

endmodule

// File: tb/approx_avg_unit_tb.sv
module approx_avg_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] x_in = '0;
    logic [9:0] y_out;
    logic       y_valid;

    int checks = 0;
    int errors = 0;
    int model_win [WIN];   // index 0 is newest
    int model_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    approx_avg_unit dut_i (
        .clk    (clk),
        .rst    (rst),
        .x_in   (x_in),
        .y_out  (y_out),
        .y_valid(y_valid)
    );

    function automatic int exp_mean();
        int s = 0;
        for (int i = 0; i < WIN; i++) s += model_win[i];
        return s / WIN;
    endfunction

    function automatic bit exp_hit();
        int m = exp_mean();
        for (int i = 0; i < WIN; i++) if (model_win[i] == m) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int exp_approx();
        int m = exp_mean();
        int best = -1;
        if (exp_hit()) return m;
        for (int i = 0; i < WIN; i++)
            if (model_win[i] < m && model_win[i] > best) best = model_win[i];
        return best;
    endfunction

    function automatic int exp_y();
        int s = 0;
        for (int i = 0; i < WIN; i++) s += model_win[i];
        return (s + WIN * exp_approx()) / (WIN - 1);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < WIN; i++) model_win[i] = 0;
        model_cnt = 0;
    endtask

    // Called at a falling edge: drive, let one rising edge pass, return at next falling edge
    task automatic push(int v);
        x_in = v[7:0];
        @(negedge clk);
        for (int i = WIN - 1; i > 0; i--) model_win[i] = model_win[i-1];
        model_win[0] = v;
        model_cnt++;
    endtask

    task automatic push_check(int v);
        push(v);
        check("R7 valid", int'(y_valid), int'(model_cnt >= WIN));
        if (model_cnt >= WIN) begin
            if (exp_hit()) check("R5 y (R1 R2 R3)", int'(y_out), exp_y());
            else           check("R5 y (R1 R2 R4)", int'(y_out), exp_y());
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model_clear();
        check("R6 valid after reset", int'(y_valid), 0);
        check("R6 y after reset", int'(y_out), 0);
        rst = 1'b0;
    endtask

    initial begin
        int ref_seq [10] = '{143, 11, 93, 32, 243, 62, 229, 3, 12, 116};
        void'($urandom(32'd5150));
        model_clear();
        @(negedge clk);
        do_reset();

        // Reference window and its successor
        for (int k = 0; k < 10; k++) begin
            push_check(ref_seq[k]);
            if (k == 8) check("R8 first window", int'(y_out), 173);
            if (k == 9) check("R8 next window", int'(y_out), 169);
        end

        // Uniform window: mean is present
        for (int k = 0; k < WIN; k++) push_check(77);
        check("R3 uniform", int'(y_out), (9*77 + 9*77) / 8);

        // All maximum samples
        for (int k = 0; k < WIN; k++) push_check(255);
        check("R5 max window", int'(y_out), 573);

        // Mean absent: eight zeros and one 90, mean 10, approx 0
        for (int k = 0; k < WIN - 1; k++) push_check(0);
        push_check(90);
        check("R4 mean absent", int'(y_out), 90 / 8);

        // Reset in the middle of a run, then refill
        do_reset();
        for (int k = 0; k < 12; k++) push_check(int'($urandom_range(0, 255)));

        // Random stream with occasional clustered values
        for (int k = 0; k < 400; k++) begin
            if (k % 37 < 9) push_check(int'($urandom_range(60, 63)));
            else            push_check(int'($urandom_range(0, 255)));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule